// File: doc/BRIEF.md
# Interrupt Drain Sequencer

This block sits beside the decode stage and controls when an interrupt is actually taken. When a request arrives, decode sends one marker micro-op down the pipeline with the single-step flag set. It then holds off all further decode of the current instruction stream. The marker travels behind every older instruction. When it reaches retirement, all older work has either committed or been squashed. This includes enable and disable writes, branch mispredicts and pending exceptions. At that point the enable state and the request are final, and the sequencer decides.

If interrupts are still enabled and the request is still present, the sequencer issues a one-cycle redirect to a fixed handler vector. If not, it drops the stall and resumes the old stream. A pipeline flush that arrives before the marker retires destroys the marker. The sequencer then returns to idle, and if the request is still asserted it sends a fresh marker one cycle later.

Top module: `irq_drain_seq`

## Requirements
- R1: During and immediately after reset (asynchronous, active-low), `stall_o`, `marker_emit_o`, `marker_sstep_o` and `redirect_valid_o` are 0 and `redirect_pc_o` is 0.
- R2: From idle, a request sampled high with no flush causes `marker_emit_o` and `marker_sstep_o` to be 1 for exactly one cycle, starting one clock after the sampling edge.
- R3: `stall_o` is 1 from the marker cycle through the whole wait and any redirect cycle, and 0 once the sequencer is idle.
- R4: Suppose the marker retires with `irq_en_i`=1, `irq_req_i`=1 and no flush. Then `redirect_valid_o` is 1 for exactly the next cycle, and the sequencer is idle the cycle after that.
- R5: If the marker retires with `irq_en_i`=0 or `irq_req_i`=0, there is no redirect, and `stall_o` is 0 on the next cycle.
- R6: A flush during the marker cycle or the wait returns the sequencer to idle on the next cycle with no redirect. This holds even if retirement is signalled in the same cycle. If the request is still high, a new marker follows one cycle later.
- R7: `marker_retired_i` has no effect while idle or in the marker cycle. In idle, a flush in the same cycle as the request delays arming by one cycle.
- R8: `redirect_pc_o` equals the parameter `HANDLER_VEC` whenever `redirect_valid_o` is 1, and is 0 otherwise.
- R9: With no retirement and no flush, the sequencer holds the stall for any number of cycles without redirecting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Level interrupt request |
| irq_en_i | input | 1 | Architectural interrupt enable, as seen at retirement |
| marker_retired_i | input | 1 | The marker micro-op retired this cycle |
| flush_i | input | 1 | Pipeline flush; kills an in-flight marker |
| stall_o | output | 1 | Hold decode of the current stream |
| marker_emit_o | output | 1 | Decode inserts the marker micro-op this cycle |
| marker_sstep_o | output | 1 | Single-step flag carried by the marker |
| redirect_valid_o | output | 1 | One-cycle fetch redirect to the handler |
| redirect_pc_o | output | ADDR_W | Redirect target, zero when not valid |

## Verification
A wrong internal state shows up at the ports within one clock. The state could get stuck in wait, skip the marker, or take a flushed or disabled interrupt. Each of these appears as a stall that persists or releases early, a missing or doubled marker pulse, or a redirect pulse in a cycle where the retire, enable and request inputs forbid it. The sweep covers every wait length from zero to four cycles. It crosses the wait lengths with every combination of enable, request and flush at retirement, and with a spurious retirement during the marker cycle. It checks every output on every cycle of each sequence.

// File: rtl/irq_drain_pkg.sv
package irq_drain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EMIT  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REDIR = 2'd3
  } drain_state_e;
endpackage

// File: rtl/irq_drain_decide.sv
module irq_drain_decide (
  input  logic irq_req_i,
  input  logic irq_en_i,
  input  logic flush_i,
  input  logic retired_i,
  output logic arm_o,
  output logic take_o,
  output logic drop_o
);
  // flush wins over every other event
  assign arm_o  = irq_req_i & ~flush_i;
  assign take_o = retired_i & ~flush_i & irq_en_i & irq_req_i;
  assign drop_o = flush_i | (retired_i & ~(irq_en_i & irq_req_i));
endmodule

// File: rtl/irq_drain_fsm.sv
module irq_drain_fsm
  import irq_drain_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         take_i,
  input  logic         drop_i,
  input  logic         flush_i,
  output drain_state_e state_o
);
  drain_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_i) state_d = ST_EMIT;
      ST_EMIT:  state_d = flush_i ? ST_IDLE : ST_WAIT;
      ST_WAIT: begin
        if (take_i)      state_d = ST_REDIR;
        else if (drop_i) state_d = ST_IDLE;
      end
      ST_REDIR: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_drain_out.sv
module irq_drain_out
  import irq_drain_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 32,
  parameter logic [ADDR_W-1:0]   HANDLER_VEC = 32'h0000_0180
) (
  input  drain_state_e      state_i,
  output logic              stall_o,
  output logic              marker_emit_o,
  output logic              marker_sstep_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  always_comb begin
    stall_o          = (state_i != ST_IDLE);
    marker_emit_o    = (state_i == ST_EMIT);
    marker_sstep_o   = (state_i == ST_EMIT);
    redirect_valid_o = (state_i == ST_REDIR);
    redirect_pc_o    = (state_i == ST_REDIR) ? HANDLER_VEC : '0;
  end
endmodule

// File: rtl/irq_drain_seq.sv
module irq_drain_seq
  import irq_drain_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 32'h0000_0180
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic              irq_en_i,
  input  logic              marker_retired_i,
  input  logic              flush_i,
  output logic              stall_o,
  output logic              marker_emit_o,
  output logic              marker_sstep_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  logic         arm, take, drop;
  drain_state_e state;

  irq_drain_decide u_decide (
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .flush_i   (flush_i),
    .retired_i (marker_retired_i),
    .arm_o     (arm),
    .take_o    (take),
    .drop_o    (drop)
  );

  irq_drain_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .take_i  (take),
    .drop_i  (drop),
    .flush_i (flush_i),
    .state_o (state)
  );

  irq_drain_out #(.ADDR_W(ADDR_W), .HANDLER_VEC(HANDLER_VEC)) u_out (
    .state_i          (state),
    .stall_o          (stall_o),
    .marker_emit_o    (marker_emit_o),
    .marker_sstep_o   (marker_sstep_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );
endmodule

// File: rtl/irq_drain_chk.sv
module irq_drain_chk #(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 32'h0000_0180
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_i,
  input logic              irq_en_i,
  input logic              marker_retired_i,
  input logic              flush_i,
  input logic              stall_o,
  input logic              marker_emit_o,
  input logic              marker_sstep_o,
  input logic              redirect_valid_o,
  input logic [ADDR_W-1:0] redirect_pc_o
);
  assert_marker_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marker_emit_o |=> !marker_emit_o);

  assert_marker_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marker_emit_o |-> marker_sstep_o);

  assert_marker_stalls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marker_emit_o |-> stall_o);

  assert_redirect_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o && !stall_o);

  assert_redirect_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> $past(marker_retired_i && irq_en_i && irq_req_i && !flush_i));

  assert_disabled_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !marker_emit_o && !redirect_valid_o && marker_retired_i && !irq_en_i)
      |=> !stall_o && !redirect_valid_o);

  assert_flush_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && stall_o && !redirect_valid_o) |=> !stall_o && !redirect_valid_o);

  assert_early_retire_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (marker_emit_o && marker_retired_i && !flush_i) |=> stall_o && !redirect_valid_o);

  assert_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_pc_o == (redirect_valid_o ? HANDLER_VEC : '0));
endmodule

bind irq_drain_seq irq_drain_chk #(.ADDR_W(ADDR_W), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .irq_req_i        (irq_req_i),
  .irq_en_i         (irq_en_i),
  .marker_retired_i (marker_retired_i),
  .flush_i          (flush_i),
  .stall_o          (stall_o),
  .marker_emit_o    (marker_emit_o),
  .marker_sstep_o   (marker_sstep_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o)
);

// File: tb/irq_drain_seq_bench.sv
`timescale 1ns/1ps
module irq_drain_seq_bench;
  localparam int unsigned       AW  = 32;
  localparam logic [AW-1:0]     VEC = 32'h0000_0180;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, en = 1'b0, ret = 1'b0, fl = 1'b0;
  logic          stall, emit, sstep, rvalid;
  logic [AW-1:0] rpc;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  irq_drain_seq #(.ADDR_W(AW), .HANDLER_VEC(VEC)) u_irq_drain_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .irq_en_i(en),
    .marker_retired_i(ret), .flush_i(fl), .stall_o(stall),
    .marker_emit_o(emit), .marker_sstep_o(sstep),
    .redirect_valid_o(rvalid), .redirect_pc_o(rpc)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input bit s, input bit e, input bit r);
    chk({tag, " stall"}, AW'(stall), AW'(s));
    chk({tag, " emit"},  AW'(emit),  AW'(e));
    chk({tag, " sstep"}, AW'(sstep), AW'(e));
    chk({tag, " rvalid"}, AW'(rvalid), AW'(r));
    chk({tag, " rpc"}, rpc, r ? VEC : '0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // leave an armed sequence through a disabled retirement
  task automatic drain_disabled();
    req = 1'b0; tick();            // now waiting
    ret = 1'b1; en = 1'b0; tick(); // released
    ret = 1'b0;
    chk_all("R5 cleanup", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_case(input int wait_n, input bit en_at, input bit req_at,
                          input bit fl_at, input bit early_ret);
    bit take;
    take = en_at && req_at && !fl_at;
    req = 1'b1; tick();
    chk_all("R2 marker", 1'b1, 1'b1, 1'b0);
    req = 1'b0; ret = early_ret; en = 1'b1; tick();
    chk_all(early_ret ? "R7 early retire" : "R3 wait entry", 1'b1, 1'b0, 1'b0);
    ret = 1'b0;
    for (int i = 0; i < wait_n; i++) begin
      tick();
      chk_all("R9 hold", 1'b1, 1'b0, 1'b0);
    end
    ret = 1'b1; en = en_at; req = req_at; fl = fl_at; tick();
    chk_all(take ? "R4 redirect" : (fl_at ? "R6 flush" : "R5 no take"), take, 1'b0, take);
    ret = 1'b0; fl = 1'b0; en = 1'b0;
    if (fl_at) begin
      req = 1'b1; tick();
      chk_all("R6 rearm", 1'b1, 1'b1, 1'b0);
      drain_disabled();
    end else begin
      req = 1'b0; tick();
      chk_all(take ? "R4 pulse end" : "R5 idle", 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #3;
    chk_all("R1 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk_all("R1 after reset", 1'b0, 1'b0, 1'b0);

    // retirement while idle
    ret = 1'b1; en = 1'b1; tick();
    chk_all("R7 idle retire", 1'b0, 1'b0, 1'b0);
    ret = 1'b0;

    // flush with request in idle delays arming
    req = 1'b1; fl = 1'b1; tick();
    chk_all("R7 idle flush", 1'b0, 1'b0, 1'b0);
    fl = 1'b0; tick();
    chk_all("R7 armed late", 1'b1, 1'b1, 1'b0);
    drain_disabled();

    // flush during marker cycle
    req = 1'b1; tick();
    chk_all("R2 marker", 1'b1, 1'b1, 1'b0);
    fl = 1'b1; tick();
    chk_all("R6 flush in marker", 1'b0, 1'b0, 1'b0);
    fl = 1'b0; tick();
    chk_all("R6 rearm", 1'b1, 1'b1, 1'b0);
    drain_disabled();

    for (int w = 0; w < 5; w++)
      for (int c = 0; c < 16; c++)
        run_case(w, c[0], c[1], c[2], c[3]);

    // asynchronous reset while waiting
    req = 1'b1; tick(); req = 1'b0; tick();
    chk_all("R9 waiting", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0; #2;
    chk_all("R1 async reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk_all("R1 after re-reset", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule